// File: doc/BRIEF.md
# Hypercube Message Routing Node

This block is the switching logic for one node of a binary n-cube message-passing network with 2^DIM nodes. It has DIM+1 input ports and DIM+1 output ports. Port 0 on each side is the local processor: messages are injected into input 0 and delivered out of output 0. Port k+1 on each side is the link along axis k, which connects to the neighbour whose address differs from this node's address only in bit k. Every port uses a valid/ready handshake: a word moves when both valid and ready are high at a clock edge.

A message is two words long. The first word is a header whose low DIM bits give the destination node address. The second word is a payload, and the node passes it through unchanged. For each header, the node XORs the destination with its own address (`self_addr`). A zero result sends the message to the local output. Otherwise the lowest set bit of the result names the axis to cross, which gives dimension-ordered routing and needs no routing table. Each output serves one message at a time. When several inputs contend for an output, a rotating arbiter chooses between them, and the losing messages wait in their input slots.

Top module: `hc_route_node`

## Requirements
- R1: After reset every `out_valid` bit is low and every `in_ready` bit is high.
- R2: A header whose destination bits (header bits DIM-1:0) equal `self_addr` leaves on output 0. Its payload follows on output 0.
- R3: For any other destination, with d = destination XOR `self_addr` and k the lowest set bit of d, the header and payload leave on output k+1. Output k+1 is the link for axis k. Both words are unchanged.
- R4: Once a header has been sent on an output, the next word sent on that output is the payload of the same message. No word of another message comes between them.
- R5: When headers from several inputs wait for the same free output, the grant rotates. The first input after the most recently granted one, in increasing index order with wrap-around, wins. After reset, input 0 has the highest priority.
- R6: While `out_valid` is high and `out_ready` is low, the output keeps `out_valid` high and holds `out_data` unchanged. No word is dropped.
- R7: Every accepted word is delivered exactly once. The words from any one input that go to a given output keep their order.
- R8: With the target output idle and ready, a header accepted at clock edge t appears on its output just after edge t+1. It is not visible just after edge t.
- R9: An input slot holds one word. While that word cannot advance, `in_ready` of that input stays low and no new word is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| self_addr | input | DIM | This node's address in the cube |
| in_valid | input | DIM+1 | Word valid per input (bit 0 local, bit k+1 axis k) |
| in_data | input | (DIM+1)*W | Input words, port i in bits i*W +: W |
| in_ready | output | DIM+1 | Input slot can take a word |
| out_valid | output | DIM+1 | Registered output word valid per output |
| out_data | output | (DIM+1)*W | Registered output words, port i in bits i*W +: W |
| out_ready | input | DIM+1 | Downstream accepts the output word |

## Verification
On every cycle, the embedded properties check three things. Each route decision selects at most one output. Each output grants at most one input and no input is drained by two outputs. A stalled output word, and a stalled input slot, stays unchanged. Each cycle they also check that the word after a header on an output comes from the same input. The bench's scenarios are needed for the rest. Lowest-set-bit axis selection and local delivery need known addresses. The rotation order of the arbiter needs a specific contention pattern. Two-edge latency, and delivery of every message exactly once under random back-pressure, depend on an end-to-end reference that tracks each message from source to output.

// File: rtl/hc_pkg.sv
package hc_pkg;
  // kind of word held in an input slot
  typedef enum logic {
    KIND_HDR = 1'b0,
    KIND_PAY = 1'b1
  } hc_kind_e;

  function automatic hc_kind_e kind_flip(hc_kind_e k);
    return (k == KIND_HDR) ? KIND_PAY : KIND_HDR;
  endfunction
endpackage

// File: rtl/hc_in_slot.sv
module hc_in_slot
  import hc_pkg::*;
#(
  parameter int DIM = 3,
  parameter int W   = 16,
  parameter int P   = DIM + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [DIM-1:0] self_addr,
  input  logic           in_valid,
  input  logic [W-1:0]   in_data,
  output logic           in_ready,
  input  logic           pop,
  output logic           slot_valid,
  output logic [W-1:0]   slot_data,
  output logic           slot_hdr,
  output logic [P-1:0]   slot_req
);
  logic           valid_q;
  logic [W-1:0]   data_q;
  hc_kind_e       kind_q;
  hc_kind_e       next_kind_q;
  logic [P-1:0]   route_q;
  logic [P-1:0]   hdr_req;
  logic [DIM-1:0] diff;
  logic           found;

  assign in_ready = !valid_q || pop;

  // lowest differing axis, local port when no axis differs
  always_comb begin
    diff    = data_q[DIM-1:0] ^ self_addr;
    hdr_req = '0;
    found   = 1'b0;
    for (int k = 0; k < DIM; k++) begin
      if (!found && diff[k]) begin
        found        = 1'b1;
        hdr_req[k+1] = 1'b1;
      end
    end
    if (!found) hdr_req[0] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q     <= 1'b0;
      data_q      <= '0;
      kind_q      <= KIND_HDR;
      next_kind_q <= KIND_HDR;
      route_q     <= '0;
    end else begin
      if (pop) begin
        valid_q <= 1'b0;
        if (kind_q == KIND_HDR) route_q <= hdr_req;
      end
      if (in_valid && in_ready) begin
        valid_q     <= 1'b1;
        data_q      <= in_data;
        kind_q      <= next_kind_q;
        next_kind_q <= kind_flip(next_kind_q);
      end
    end
  end

  assign slot_valid = valid_q;
  assign slot_data  = data_q;
  assign slot_hdr   = (kind_q == KIND_HDR);
  assign slot_req   = !valid_q ? '0 : ((kind_q == KIND_HDR) ? hdr_req : route_q);

  // R3: a word asks for at most one output
  p_route_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(slot_req));

  // R9: a word that does not advance stays in its slot untouched
  p_slot_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !pop) |=> (valid_q && $stable(data_q)));
endmodule

// File: rtl/hc_out_port.sv
module hc_out_port #(
  parameter int P = 4,
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [P-1:0]   req,
  input  logic [P-1:0]   is_hdr,
  input  logic [P*W-1:0] flit_data,
  input  logic           out_ready,
  output logic [P-1:0]   grant,
  output logic           out_valid,
  output logic [W-1:0]   out_data
);
  localparam int IW = (P > 1) ? $clog2(P) : 1;

  logic          busy_q;
  logic [IW-1:0] owner_q;
  logic [IW-1:0] rr_q;
  logic          ov_q;
  logic [W-1:0]  od_q;

  logic          can_take;
  logic [P-1:0]  hreq;
  logic [IW-1:0] pick;
  logic          pick_ok;
  logic [IW-1:0] sel;

  assign can_take = !ov_q || out_ready;

  // rotating search starting after the last winner
  always_comb begin
    hreq    = req & is_hdr;
    pick    = '0;
    pick_ok = 1'b0;
    for (int off = 1; off <= P; off++) begin
      int idx;
      idx = int'(rr_q) + off;
      if (idx >= P) idx = idx - P;
      if (!pick_ok && hreq[idx]) begin
        pick_ok = 1'b1;
        pick    = IW'(idx);
      end
    end
  end

  always_comb begin
    grant = '0;
    sel   = busy_q ? owner_q : pick;
    if (can_take) begin
      if (busy_q) begin
        if (req[owner_q] && !is_hdr[owner_q]) grant[owner_q] = 1'b1;
      end else if (pick_ok) begin
        grant[pick] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
      rr_q    <= IW'(P - 1);
      ov_q    <= 1'b0;
      od_q    <= '0;
    end else begin
      if (|grant) begin
        ov_q <= 1'b1;
        od_q <= flit_data[int'(sel)*W +: W];
        if (busy_q) begin
          busy_q <= 1'b0;
        end else begin
          busy_q  <= 1'b1;
          owner_q <= pick;
          rr_q    <= pick;
        end
      end else if (out_ready) begin
        ov_q <= 1'b0;
      end
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;

  // R7: one input served per output per cycle
  p_one_grant_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R6: stalled output word is held
  p_out_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R4: after a header, the next grant on this output is the same input
  p_pay_follows_r4: assert property (@(posedge clk) disable iff (rst)
    (|(grant & is_hdr)) |=> ((grant == '0) || (grant == $past(grant))));
endmodule

// File: rtl/hc_route_node.sv
module hc_route_node #(
  parameter int DIM = 3,
  parameter int W   = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [DIM-1:0]         self_addr,
  input  logic [DIM:0]           in_valid,
  input  logic [(DIM+1)*W-1:0]   in_data,
  output logic [DIM:0]           in_ready,
  output logic [DIM:0]           out_valid,
  output logic [(DIM+1)*W-1:0]   out_data,
  input  logic [DIM:0]           out_ready
);
  localparam int P = DIM + 1;

  logic [P-1:0]   slot_valid;
  logic [P*W-1:0] slot_data;
  logic [P-1:0]   slot_hdr;
  logic [P-1:0]   slot_req [P];   // per input: wanted outputs
  logic [P-1:0]   req_t    [P];   // per output: requesting inputs
  logic [P-1:0]   grant_m  [P];   // per output: granted input
  logic [P-1:0]   col      [P];   // per input: outputs granting it
  logic [P-1:0]   pop;

  always_comb begin
    for (int o = 0; o < P; o++) begin
      for (int i = 0; i < P; i++) begin
        req_t[o][i] = slot_req[i][o];
        col[i][o]   = grant_m[o][i];
      end
    end
    for (int i = 0; i < P; i++) pop[i] = |col[i];
  end

  for (genvar i = 0; i < P; i++) begin : g_in
    hc_in_slot #(.DIM(DIM), .W(W), .P(P)) u_slot (
      .clk        (clk),
      .rst        (rst),
      .self_addr  (self_addr),
      .in_valid   (in_valid[i]),
      .in_data    (in_data[i*W +: W]),
      .in_ready   (in_ready[i]),
      .pop        (pop[i]),
      .slot_valid (slot_valid[i]),
      .slot_data  (slot_data[i*W +: W]),
      .slot_hdr   (slot_hdr[i]),
      .slot_req   (slot_req[i])
    );

    // R7: a word is taken by at most one output
    p_single_pop_r7: assert property (@(posedge clk) disable iff (rst)
      $onehot0(col[i]));

    // R9: only a present word can be taken
    p_pop_valid_r9: assert property (@(posedge clk) disable iff (rst)
      pop[i] |-> slot_valid[i]);
  end

  for (genvar o = 0; o < P; o++) begin : g_out
    hc_out_port #(.P(P), .W(W)) u_port (
      .clk       (clk),
      .rst       (rst),
      .req       (req_t[o]),
      .is_hdr    (slot_hdr),
      .flit_data (slot_data),
      .out_ready (out_ready[o]),
      .grant     (grant_m[o]),
      .out_valid (out_valid[o]),
      .out_data  (out_data[o*W +: W])
    );
  end
endmodule

// File: tb/sim_hc_route_node.sv
`timescale 1ns/1ps
module sim_hc_route_node;
  localparam int DIM = 3;
  localparam int W   = 16;
  localparam int P   = DIM + 1;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [DIM-1:0] self_addr = 3'd5;
  logic [P-1:0]   in_valid = '0;
  logic [P*W-1:0] in_data = '0;
  logic [P-1:0]   in_ready;
  logic [P-1:0]   out_valid;
  logic [P*W-1:0] out_data;
  logic [P-1:0]   out_ready = '0;

  always #4 clk = ~clk;

  hc_route_node #(.DIM(DIM), .W(W)) u0 (
    .clk(clk), .rst(rst), .self_addr(self_addr),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  int n_chk = 0;
  int n_fail = 0;
  int seq = 0;
  logic [W-1:0] txq  [P][$];
  logic [W-1:0] expq [P][P][$];
  int           hdr_log [P][$];
  logic [P-1:0] hs_in = '0;
  bit           ophase [P];
  int           olock  [P];
  logic [P-1:0] rdy_force = '1;
  bit           rnd_rdy = 1'b0;

  task automatic fail(string rq, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_fail++;
    $display("FAIL %s: %s actual=%h expected=%h", rq, what, act, exp);
  endtask

  task automatic chk(bit ok, string rq, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (!ok) fail(rq, what, act, exp);
  endtask

  function automatic int route_of(int self, int dst);
    int x;
    x = self ^ dst;
    if (x == 0) return 0;
    for (int k = 0; k < DIM; k++) if (x[k]) return k + 1;
    return 0;
  endfunction

  task automatic send_msg(int src, int dst, output logic [W-1:0] hdr);
    logic [W-1:0] pay;
    int o;
    hdr = {4'(src), 1'b0, 8'(seq), 3'(dst)};
    pay = {4'(src), 1'b1, 8'(seq), 3'(seq * 3)};
    seq++;
    o = route_of(int'(self_addr), dst);
    txq[src].push_back(hdr);
    txq[src].push_back(pay);
    expq[src][o].push_back(hdr);
    expq[src][o].push_back(pay);
  endtask

  task automatic take(int o, logic [W-1:0] d);
    int s;
    bit pay;
    s   = int'(d[15:12]);
    pay = d[11];
    n_chk++;
    if (ophase[o] && (!pay || s != olock[o])) begin
      fail("R4", $sformatf("port %0d word after header from other message", o), d, W'(olock[o]));
    end else if (!ophase[o] && pay) begin
      fail("R4", $sformatf("port %0d payload without header", o), d, '0);
    end
    n_chk++;
    if (s >= P || expq[s][o].size() == 0) begin
      fail("R3", $sformatf("unexpected word on port %0d", o), d, '0);
    end else begin
      if (expq[s][o][0] !== d)
        fail("R3", $sformatf("port %0d word from input %0d", o, s), d, expq[s][o][0]);
      void'(expq[s][o].pop_front());
    end
    if (!pay) begin
      hdr_log[o].push_back(s);
      olock[o]  = s;
      ophase[o] = 1'b1;
    end else begin
      ophase[o] = 1'b0;
    end
  endtask

  // one clock: drive at the falling edge, sample handshakes just after
  task automatic tick();
    @(negedge clk);
    for (int i = 0; i < P; i++) if (hs_in[i]) void'(txq[i].pop_front());
    for (int i = 0; i < P; i++) begin
      in_valid[i] = (txq[i].size() != 0);
      in_data[i*W +: W] = (txq[i].size() != 0) ? txq[i][0] : '0;
    end
    for (int o = 0; o < P; o++)
      out_ready[o] = rnd_rdy ? ($urandom_range(0, 9) < 7) : rdy_force[o];
    #1;
    for (int i = 0; i < P; i++) hs_in[i] = in_valid[i] && in_ready[i];
    for (int o = 0; o < P; o++)
      if (out_valid[o] && out_ready[o]) take(o, out_data[o*W +: W]);
  endtask

  function automatic bit busy();
    if (out_valid != '0 || hs_in != '0) return 1'b1;
    for (int i = 0; i < P; i++) begin
      if (txq[i].size() != 0) return 1'b1;
      for (int o = 0; o < P; o++) if (expq[i][o].size() != 0) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic drain(int lim);
    int n;
    n = 0;
    while (busy() && n < lim) begin
      tick();
      n++;
    end
    chk(n < lim, "R7", "watchdog: traffic did not drain", W'(n), W'(lim));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 180000);
    n_chk++;
    fail("R7", "global watchdog expired", '0, '0);
    finish_run();
  end

  initial begin
    logic [W-1:0] h;
    logic [W-1:0] held;
    for (int o = 0; o < P; o++) begin
      ophase[o] = 1'b0;
      olock[o]  = 0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    tick();
    chk(out_valid == '0, "R1", "out_valid after reset", W'(out_valid), '0);
    chk(in_ready == '1, "R1", "in_ready after reset", W'(in_ready), W'(4'hF));

    // R8 / R2: local delivery latency, self 5
    rdy_force = '1;
    send_msg(0, 5, h);
    tick();
    chk(hs_in[0], "R8", "header offered and taken", W'(hs_in[0]), 1);
    tick();
    chk(out_valid == '0, "R8", "output one edge after accept", W'(out_valid), '0);
    tick();
    chk(out_valid[0], "R2", "local header on output 0", W'(out_valid), 1);
    chk(out_data[0 +: W] == h, "R8", "header two edges after accept", out_data[0 +: W], h);
    drain(100);

    // R3: axis selection from input 0
    send_msg(0, 4, h);   // xor 001 -> port 1
    send_msg(0, 1, h);   // xor 100 -> port 3
    send_msg(0, 2, h);   // xor 111 -> port 1 (lowest bit)
    send_msg(0, 7, h);   // xor 010 -> port 2
    send_msg(3, 5, h);   // local from a link input
    drain(200);

    // R5: rotation (fixed priority would give 1,1,2)
    for (int o = 0; o < P; o++) hdr_log[o].delete();
    send_msg(1, 5, h);
    send_msg(1, 5, h);
    send_msg(2, 5, h);
    drain(200);
    chk(hdr_log[0].size() == 3, "R5", "header count on port 0", W'(hdr_log[0].size()), 3);
    if (hdr_log[0].size() == 3) begin
      chk(hdr_log[0][0] == 1, "R5", "first winner", W'(hdr_log[0][0]), 1);
      chk(hdr_log[0][1] == 2, "R5", "second winner rotates", W'(hdr_log[0][1]), 2);
      chk(hdr_log[0][2] == 1, "R5", "third winner", W'(hdr_log[0][2]), 1);
    end

    // R6 / R9: back-pressure on port 2
    rdy_force = 4'b1011;
    send_msg(0, 7, h);
    send_msg(0, 7, h);
    repeat (3) tick();
    held = out_data[2*W +: W];
    chk(out_valid[2], "R6", "stalled port holds valid", W'(out_valid), 4);
    chk(held == h - 16'd0 || held[11] == 1'b0, "R6", "stalled port shows a header", held, '0);
    repeat (5) begin
      tick();
      chk(out_valid[2] && out_data[2*W +: W] == held, "R6", "stalled word stable",
          out_data[2*W +: W], held);
    end
    chk(in_valid[0] && !in_ready[0], "R9", "full slot refuses word", W'(in_ready), 0);
    rdy_force = '1;
    drain(200);

    // R7: random traffic and back-pressure, two node addresses
    for (int pass = 0; pass < 2; pass++) begin
      self_addr = (pass == 0) ? 3'd2 : 3'd0;
      rnd_rdy = 1'b1;
      for (int m = 0; m < 30; m++)
        for (int i = 0; i < P; i++) send_msg(i, $urandom_range(0, 7), h);
      drain(5000);
      rnd_rdy = 1'b0;
      for (int i = 0; i < P; i++)
        for (int o = 0; o < P; o++)
          chk(expq[i][o].size() == 0, "R7", "all messages delivered",
              W'(expq[i][o].size()), 0);
    end
    finish_run();
  end
endmodule